// File: doc/BRIEF.md
# Maskable Sticky Event Interrupt Controller

The block collects seven status-change events from a timing subsystem into a sticky status register. It watches a reference-qualification status vector, the selected-reference code of two timing generators, the lock state of those two generators and an out-event line from each generator. A change on a level or code input, or a rising edge on an out-event line, sets one status bit. The bit stays set until software clears it.

A simple register bus reads the status and clears bits by writing ones. The same bus reads and writes a mask register and a two-bit output configuration register. The single interrupt pin is asserted whenever any status bit that is also enabled in the mask is set. The configuration picks the asserted level of the pin. It also picks whether the idle pin is driven to its inactive level or released to high impedance, which lets several open-drain style sources share one wire.

Top module: `evt_irq_ctrl`

## Requirements
- R1: Register map on `bus_addr`: 0 is status (write-one-to-clear), 1 is mask (read/write, bit i enables status bit i), 2 is configuration (read/write, bit 0 = active-high polarity, bit 1 = tri-state when idle), and 3 reads as zero. `bus_rdata` is registered and shows, after each rising edge, the register that `bus_addr` selected at that edge, zero-extended.
- R2: The status bit positions are: bit 0 = qualification vector changed, bit 1 = generator A selected reference changed, bit 2 = generator B selected reference changed, bit 3 = generator A lock state changed, bit 4 = generator B lock state changed, bit 5 = rising edge of out-event A, bit 6 = rising edge of out-event B. A falling edge on an out-event sets nothing. An input that holds its value sets nothing. An event bit is set by the second rising edge after the input change.
- R3: A set status bit stays set while its input returns or holds, and hardware never clears it.
- R4: A bus write to address 0 clears every status bit written as 1. Bits written as 0 keep their value.
- R5: When a new event and a clearing write hit the same status bit in the same cycle, the bit stays set. Other bits cleared by that write still clear.
- R6: The interrupt is active when status AND mask has any bit set. `irq_o` and `irq_oe` are registered and follow a status, mask or configuration change one edge later.
- R7: Configuration bit 0 at 0 makes the active level 0 and the inactive level 1. At 1 the active level is 1 and the inactive level is 0.
- R8: With configuration bit 1 at 0, `irq_oe` is always 1. With bit 1 at 1, `irq_oe` is 1 only while the interrupt is active. `irq_o` always carries the active or inactive level.
- R9: Synchronous reset clears status, mask and configuration, so the pin resets to active low and driven, with `irq_o` = 1 and `irq_oe` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| qual_stat | input | QUAL_W | Reference qualification status vector |
| sel_ref_a | input | REF_W | Generator A selected reference code |
| sel_ref_b | input | REF_W | Generator B selected reference code |
| lock_a | input | LOCK_W | Generator A lock state |
| lock_b | input | LOCK_W | Generator B lock state |
| oev_a | input | 1 | Generator A out-event line |
| oev_b | input | 1 | Generator B out-event line |
| irq_o | output | 1 | Interrupt pin level |
| irq_oe | output | 1 | Interrupt pin output enable |

## Verification
A vector table changes the inputs one at a time and then several at once. This separates a correct bit position from a shared or swapped one. Holding vectors and falling out-event edges show that change detection does not fire on level alone. Directed sequences then exercise the pin with the mask on and off, both polarities and both idle modes. A write of zero, a clear issued in the same cycle as a fresh event, and an unmapped read cover the remaining corners.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;
  localparam int NUM_EVT  = 7;
  localparam int EV_QUAL  = 0;
  localparam int EV_SELA  = 1;
  localparam int EV_SELB  = 2;
  localparam int EV_LOCKA = 3;
  localparam int EV_LOCKB = 4;
  localparam int EV_OEVA  = 5;
  localparam int EV_OEVB  = 6;

  localparam logic [1:0] A_STAT = 2'd0;
  localparam logic [1:0] A_MASK = 2'd1;
  localparam logic [1:0] A_CFG  = 2'd2;

  typedef struct packed {
    logic idle_tri;
    logic act_high;
  } pin_cfg_t;
endpackage

// File: rtl/evt_detect.sv
module evt_detect #(
  parameter int W    = 1,
  parameter bit RISE = 1'b0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic         hit
);
  logic [W-1:0] cur_q;
  logic [W-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_q  <= '0;
      prev_q <= '0;
    end else begin
      cur_q  <= d;
      prev_q <= cur_q;
    end
  end

  generate
    if (RISE) begin : g_rise
      assign hit = cur_q[0] & ~prev_q[0];
      if (W > 1) begin : g_spare
        logic unused_hi;
        assign unused_hi = ^{cur_q[W-1:1], prev_q[W-1:1]};
      end
    end else begin : g_change
      assign hit = (cur_q != prev_q);
    end
  endgenerate
endmodule

// File: rtl/evt_status.sv
module evt_status #(
  parameter int N = 7
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] ev,
  input  logic [N-1:0] clr,
  output logic [N-1:0] status
);
  always_ff @(posedge clk) begin
    if (rst) status <= '0;
    else     status <= (status & ~clr) | ev;
  end
endmodule

// File: rtl/evt_pin.sv
module evt_pin #(
  parameter int N = 7
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [N-1:0]          status,
  input  logic [N-1:0]          mask,
  input  evt_irq_pkg::pin_cfg_t cfg,
  output logic                  irq_o,
  output logic                  irq_oe
);
  logic active;
  assign active = |(status & mask);

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_o  <= 1'b1;
      irq_oe <= 1'b1;
    end else begin
      irq_o  <= active ? cfg.act_high : ~cfg.act_high;
      irq_oe <= active | ~cfg.idle_tri;
    end
  end
endmodule

// File: rtl/evt_irq_ctrl.sv
module evt_irq_ctrl #(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 8,
  parameter int QUAL_W = 4,
  parameter int REF_W  = 3,
  parameter int LOCK_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [QUAL_W-1:0] qual_stat,
  input  logic [REF_W-1:0]  sel_ref_a,
  input  logic [REF_W-1:0]  sel_ref_b,
  input  logic [LOCK_W-1:0] lock_a,
  input  logic [LOCK_W-1:0] lock_b,
  input  logic              oev_a,
  input  logic              oev_b,
  output logic              irq_o,
  output logic              irq_oe
);
  import evt_irq_pkg::*;
  localparam int N = NUM_EVT;

  logic [N-1:0] ev_vec;
  logic [N-1:0] clr_vec;
  logic [N-1:0] status_q;
  logic [N-1:0] mask_q;
  pin_cfg_t     cfg_q;
  logic         wr_stat, wr_mask, wr_cfg;

  evt_detect #(.W(QUAL_W), .RISE(1'b0)) u_det_qual (.clk(clk), .rst(rst), .d(qual_stat), .hit(ev_vec[EV_QUAL]));
  evt_detect #(.W(REF_W),  .RISE(1'b0)) u_det_sela (.clk(clk), .rst(rst), .d(sel_ref_a), .hit(ev_vec[EV_SELA]));
  evt_detect #(.W(REF_W),  .RISE(1'b0)) u_det_selb (.clk(clk), .rst(rst), .d(sel_ref_b), .hit(ev_vec[EV_SELB]));
  evt_detect #(.W(LOCK_W), .RISE(1'b0)) u_det_lka  (.clk(clk), .rst(rst), .d(lock_a),    .hit(ev_vec[EV_LOCKA]));
  evt_detect #(.W(LOCK_W), .RISE(1'b0)) u_det_lkb  (.clk(clk), .rst(rst), .d(lock_b),    .hit(ev_vec[EV_LOCKB]));
  evt_detect #(.W(1),      .RISE(1'b1)) u_det_oea  (.clk(clk), .rst(rst), .d(oev_a),     .hit(ev_vec[EV_OEVA]));
  evt_detect #(.W(1),      .RISE(1'b1)) u_det_oeb  (.clk(clk), .rst(rst), .d(oev_b),     .hit(ev_vec[EV_OEVB]));

  assign wr_stat = bus_wr && (bus_addr == ADDR_W'(A_STAT));
  assign wr_mask = bus_wr && (bus_addr == ADDR_W'(A_MASK));
  assign wr_cfg  = bus_wr && (bus_addr == ADDR_W'(A_CFG));
  assign clr_vec = wr_stat ? bus_wdata[N-1:0] : '0;

  generate
    if (DATA_W > N) begin : g_wd_spare
      logic unused_wd;
      assign unused_wd = ^bus_wdata[DATA_W-1:N];
    end
  endgenerate

  evt_status #(.N(N)) u_status (
    .clk(clk), .rst(rst), .ev(ev_vec), .clr(clr_vec), .status(status_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '0;
      cfg_q  <= '0;
    end else begin
      if (wr_mask) mask_q <= bus_wdata[N-1:0];
      if (wr_cfg)  cfg_q  <= pin_cfg_t'(bus_wdata[1:0]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else begin
      unique case (bus_addr)
        ADDR_W'(A_STAT): bus_rdata <= DATA_W'(status_q);
        ADDR_W'(A_MASK): bus_rdata <= DATA_W'(mask_q);
        ADDR_W'(A_CFG):  bus_rdata <= DATA_W'(cfg_q);
        default:         bus_rdata <= '0;
      endcase
    end
  end

  evt_pin #(.N(N)) u_pin (
    .clk(clk), .rst(rst), .status(status_q), .mask(mask_q), .cfg(cfg_q),
    .irq_o(irq_o), .irq_oe(irq_oe)
  );
endmodule

// File: rtl/evt_irq_chk.sv
module evt_irq_chk #(
  parameter int N = 7
) (
  input logic         clk,
  input logic         rst,
  input logic [N-1:0] status,
  input logic [N-1:0] mask,
  input logic [N-1:0] ev,
  input logic [N-1:0] clr,
  input logic [1:0]   cfg,
  input logic         irq_o,
  input logic         irq_oe
);
  AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (rst)
    (status & ~$past(status) & ~$past(ev)) == '0); // R2

  AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (rst)
    ((status & ~clr) != '0) |=> ((status & $past(status & ~clr)) == $past(status & ~clr))); // R3

  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (rst)
    ((clr & ~ev) != '0) |=> ((status & $past(clr & ~ev)) == '0)); // R4

  AST_EVENT_WINS: assert property (@(posedge clk) disable iff (rst)
    (ev != '0) |=> ((status & $past(ev)) == $past(ev))); // R5

  AST_PIN_LEVEL: assert property (@(posedge clk) disable iff (rst)
    irq_o == ($past(|(status & mask)) ? $past(cfg[0]) : !$past(cfg[0]))); // R7

  AST_PIN_ENABLE: assert property (@(posedge clk) disable iff (rst)
    irq_oe == ($past(|(status & mask)) || !$past(cfg[1]))); // R8
endmodule

bind evt_irq_ctrl evt_irq_chk #(.N(evt_irq_pkg::NUM_EVT)) u_chk (
  .clk(clk), .rst(rst), .status(status_q), .mask(mask_q), .ev(ev_vec),
  .clr(clr_vec), .cfg(cfg_q), .irq_o(irq_o), .irq_oe(irq_oe)
);

// File: tb/evt_irq_ctrl_bench.sv
module evt_irq_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_wr = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic [3:0] qual = '0;
  logic [2:0] sela = '0, selb = '0;
  logic [1:0] locka = '0, lockb = '0;
  logic       oa = 1'b0, ob = 1'b0;
  logic       irq_o, irq_oe;
  int nvec = 0, nfail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  evt_irq_ctrl u_evt_irq_ctrl (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .qual_stat(qual),
    .sel_ref_a(sela), .sel_ref_b(selb), .lock_a(locka), .lock_b(lockb),
    .oev_a(oa), .oev_b(ob), .irq_o(irq_o), .irq_oe(irq_oe)
  );

  // fields: qual[22:19] sela[18:16] selb[15:13] locka[12:11] lockb[10:9] oa[8] ob[7] expected[6:0]
  localparam int NV = 12;
  localparam logic [22:0] VEC [NV] = '{
    {4'h0, 3'd0, 3'd0, 2'd0, 2'd0, 1'b0, 1'b0, 7'h00},
    {4'h1, 3'd0, 3'd0, 2'd0, 2'd0, 1'b0, 1'b0, 7'h01},
    {4'h1, 3'd2, 3'd0, 2'd0, 2'd0, 1'b0, 1'b0, 7'h02},
    {4'h1, 3'd2, 3'd5, 2'd0, 2'd0, 1'b0, 1'b0, 7'h04},
    {4'h1, 3'd2, 3'd5, 2'd1, 2'd0, 1'b0, 1'b0, 7'h08},
    {4'h1, 3'd2, 3'd5, 2'd1, 2'd3, 1'b0, 1'b0, 7'h10},
    {4'h1, 3'd2, 3'd5, 2'd1, 2'd3, 1'b1, 1'b0, 7'h20},
    {4'h1, 3'd2, 3'd5, 2'd1, 2'd3, 1'b1, 1'b1, 7'h40},
    {4'h1, 3'd2, 3'd5, 2'd1, 2'd3, 1'b0, 1'b0, 7'h00},
    {4'h1, 3'd2, 3'd5, 2'd1, 2'd3, 1'b0, 1'b0, 7'h00},
    {4'h8, 3'd2, 3'd5, 2'd0, 2'd3, 1'b1, 1'b0, 7'h29},
    {4'h8, 3'd3, 3'd4, 2'd0, 2'd0, 1'b0, 1'b1, 7'h56}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    @(negedge clk);
    bus_addr = a;
    @(negedge clk);
    v = bus_rdata;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] v);
    @(negedge clk);
    bus_addr = a; bus_wdata = v; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R9 reset state
    chk("R9 irq_o after reset", {7'd0, irq_o}, 8'd1);
    chk("R9 irq_oe after reset", {7'd0, irq_oe}, 8'd1);
    rd(2'd0, v); chk("R9 status reset", v, 8'h00);
    rd(2'd1, v); chk("R9 mask reset", v, 8'h00);
    rd(2'd2, v); chk("R9 cfg reset", v, 8'h00);

    // R2 table of single and combined input changes
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      {qual, sela, selb, locka, lockb, oa, ob} = VEC[i][22:7];
      idle(3);
      rd(2'd0, v);
      chk($sformatf("R2 vector %0d status", i), v, {1'b0, VEC[i][6:0]});
      wr(2'd0, 8'h7F);
    end

    // R1 / R6 mask and pin assertion
    wr(2'd1, 8'h20);
    rd(2'd1, v); chk("R1 mask readback", v, 8'h20);
    chk("R6 pin idle with no status", {7'd0, irq_o}, 8'd1);
    @(negedge clk); oa = 1'b1;
    idle(4);
    chk("R6 pin asserted low", {7'd0, irq_o}, 8'd0);
    chk("R6 pin driven", {7'd0, irq_oe}, 8'd1);
    @(negedge clk); oa = 1'b0;
    idle(3);
    rd(2'd0, v); chk("R3 status sticky", v, 8'h20);
    chk("R3 pin still asserted", {7'd0, irq_o}, 8'd0);

    // R4 writing zero keeps bits
    wr(2'd0, 8'h00);
    rd(2'd0, v); chk("R4 zero write no effect", v, 8'h20);

    // R6 masking removes assertion
    wr(2'd1, 8'h00);
    idle(2);
    chk("R6 masked pin inactive", {7'd0, irq_o}, 8'd1);

    // R7 active-high polarity
    wr(2'd2, 8'h01);
    wr(2'd1, 8'h20);
    idle(2);
    chk("R7 active high asserted", {7'd0, irq_o}, 8'd1);
    wr(2'd0, 8'h20);
    idle(2);
    chk("R7 active high inactive", {7'd0, irq_o}, 8'd0);
    rd(2'd0, v); chk("R4 one clears", v, 8'h00);

    // R8 tri-state idle
    wr(2'd2, 8'h03);
    idle(2);
    chk("R8 idle released", {7'd0, irq_oe}, 8'd0);
    rd(2'd2, v); chk("R1 cfg readback", v, 8'h03);
    @(negedge clk); oa = 1'b1;
    idle(4);
    chk("R8 enable while active", {7'd0, irq_oe}, 8'd1);
    chk("R8 level while active", {7'd0, irq_o}, 8'd1);
    @(negedge clk); oa = 1'b0;
    idle(3);

    // R5 event and clear in the same cycle
    @(negedge clk); ob = 1'b0;
    idle(3);
    @(negedge clk); ob = 1'b1;
    idle(3);
    rd(2'd0, v); chk("R5 setup status", v, 8'h60);
    @(negedge clk); oa = 1'b1;
    @(negedge clk);
    bus_addr = 2'd0; bus_wdata = 8'h60; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
    rd(2'd0, v); chk("R5 event wins over clear", v, 8'h20);

    // R1 unmapped address
    rd(2'd3, v); chk("R1 unmapped reads zero", v, 8'h00);

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule